// File: doc/BRIEF.md
# Vectored interrupt flag controller

This block keeps a pending flag and a permit flag for each of ten interrupt sources and turns the pairs that are both set into vectored requests for a CPU. The sources report through one-cycle event pulses. The CPU reaches both flag banks through a small register port that writes either one bit or a whole 4-bit nibble. A master enable gates what the CPU sees, and an acknowledge carrying a vector index tells the block which service has just been entered.

Nine vectors cover the ten sources. External pin 4 and the basic interval timer share one vector, and their pending flags follow their own clearing rule on acknowledge. Every other vector clears its source's pending flag when it is acknowledged. A wake output tells the standby logic that some qualified request exists, whatever the master enable says. A pending flag set by a CPU write counts exactly like one set by an event.

Top module: `irq_vec_ctrl`

## Requirements
- R1: While rst_ni is low, and after it rises, every pending and permit flag reads 0, and vec_valid_o and wake_o are 0.
- R2: A pulse on evt_i[k] sets pending flag k on the next clock edge. This holds even when, in the same cycle, a CPU write clears that flag or an acknowledge would clear it.
- R3: wake_o is 1 exactly when at least one source has both its pending and its permit flag set. mie_i has no effect on it.
- R4: vec_valid_o is mie_i ANDed with "some vector is requested", and vec_idx_o gives the lowest requested vector. The vector map is: vectors 0, 1 and 2 serve sources 0, 1 and 2 (pins 0, 1 and 2). Vector 3 serves sources 3 (pin 4) and 4 (interval timer). Vectors 4 to 8 serve sources 5 to 9 (serial, timer/counter, pulse generator, key scanner, watch timer). A vector is requested while any of its sources has both flags set.
- R5: reg_addr_i[2] selects the bank: 0 for pending, 1 for permit. reg_addr_i[1:0] selects nibble n, which holds sources 4n to 4n+3, with bit b holding source 4n+b. reg_rdata_o always shows the addressed nibble. When reg_we_i is 1 and reg_bit_i is 0, all four bits are written from reg_wdata_i. When reg_we_i is 1 and reg_bit_i is 1, only bit reg_bsel_i is written, and it takes reg_wdata_i[0]. Bits above source 9 read 0 and ignore writes. A CPU write overrides an acknowledge clear in the same cycle.
- R6: A pending flag set by a CPU write, with its permit flag set, raises the vectored request just as an event does.
- R7: Acknowledging any vector except vector 3 clears the pending flag of its source on the next edge. An acknowledge index above 8 changes nothing.
- R8: Acknowledging vector 3 clears whichever of sources 3 and 4 is the only one with both flags set. If both are qualified, neither flag is cleared. A pending flag whose permit flag is 0 is never cleared by the acknowledge.
- R9: Permit flags change only through CPU writes. Events and acknowledges leave them unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| evt_i | input | 10 | One-cycle event pulse per source |
| reg_we_i | input | 1 | Register write strobe |
| reg_bit_i | input | 1 | 1 = single-bit write, 0 = nibble write |
| reg_addr_i | input | 3 | Bank select (bit 2) and nibble index (bits 1:0) |
| reg_bsel_i | input | 2 | Bit within the nibble for single-bit writes |
| reg_wdata_i | input | 4 | Write data |
| reg_rdata_o | output | 4 | Addressed nibble |
| mie_i | input | 1 | Master enable for the CPU request |
| ack_i | input | 1 | Service-entry acknowledge |
| ack_idx_i | input | 4 | Vector being acknowledged |
| vec_valid_o | output | 1 | A vectored request is presented |
| vec_idx_o | output | 4 | Lowest requested vector |
| wake_o | output | 1 | Standby release |

## Verification
The directed part goes after the shared vector. It acknowledges vector 3 with both sources qualified, with only one qualified, and with one pending but not permitted. A design that used the ordinary clearing rule there would drop a request that software still has to test, or would clear a flag that was never serviced. It also fires an event while the same flag is being cleared by a CPU write or an acknowledge. A wrong precedence would lose the event, and the readback would show the flag missing. Random traffic mixes events, bit and nibble writes, reads and acknowledges with mie_i toggling. This exposes wrong priority order, a wake output gated by mie_i, and writes that leak into the unused bits above source 9.

// File: rtl/irq_vec_pkg.sv
`timescale 1ns/1ps
package irq_vec_pkg;
  localparam int NUM_SRC    = 10;
  localparam int NUM_VEC    = NUM_SRC - 1;
  localparam int IDX_W      = 4;
  localparam int NIB_W      = 4;
  localparam int ADDR_W     = 3;
  localparam int SEL_W      = 2;
  localparam int SHARED_VEC = 3;
  localparam int SHARED_LO  = 3;
  localparam int SHARED_HI  = 4;

  // source served by a non-shared vector
  function automatic int vec_src(input int v);
    if (v < SHARED_VEC) return v;
    if (v == SHARED_VEC) return SHARED_LO;
    return v + 1;
  endfunction
endpackage

// File: rtl/irq_flag_bank.sv
`timescale 1ns/1ps
module irq_flag_bank #(
  parameter int N = 10
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  input  logic [N-1:0] wr_en_i,
  input  logic [N-1:0] wr_val_i,
  output logic [N-1:0] q_o
);
  logic [N-1:0] q_d;

  // write beats clear, set beats both
  assign q_d = set_i | (wr_en_i & wr_val_i) | (~wr_en_i & q_o & ~clr_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= '0;
    else         q_o <= q_d;
  end
endmodule

// File: rtl/irq_vec_select.sv
`timescale 1ns/1ps
module irq_vec_select
  import irq_vec_pkg::*;
(
  input  logic [NUM_SRC-1:0] qual_i,
  output logic               any_o,
  output logic [IDX_W-1:0]   idx_o
);
  logic [NUM_VEC-1:0] pend;

  for (genvar v = 0; v < NUM_VEC; v++) begin : g_pend
    if (v == SHARED_VEC) begin : g_shared
      assign pend[v] = qual_i[SHARED_LO] | qual_i[SHARED_HI];
    end else begin : g_single
      assign pend[v] = qual_i[vec_src(v)];
    end
  end

  assign any_o = |pend;

  always_comb begin
    idx_o = '0;
    for (int v = NUM_VEC - 1; v >= 0; v--) begin
      if (pend[v]) idx_o = IDX_W'(v);
    end
  end
endmodule

// File: rtl/irq_ack_clear.sv
`timescale 1ns/1ps
module irq_ack_clear
  import irq_vec_pkg::*;
(
  input  logic               ack_i,
  input  logic [IDX_W-1:0]   ack_idx_i,
  input  logic [NUM_SRC-1:0] qual_i,
  output logic [NUM_SRC-1:0] clr_o
);
  for (genvar v = 0; v < NUM_VEC; v++) begin : g_clr
    if (v == SHARED_VEC) begin : g_shared
      logic hit;
      assign hit = ack_i && (ack_idx_i == IDX_W'(v));
      // only the lone qualified source of the pair is cleared
      assign clr_o[SHARED_LO] = hit && qual_i[SHARED_LO] && !qual_i[SHARED_HI];
      assign clr_o[SHARED_HI] = hit && qual_i[SHARED_HI] && !qual_i[SHARED_LO];
    end else begin : g_single
      assign clr_o[vec_src(v)] = ack_i && (ack_idx_i == IDX_W'(v));
    end
  end
endmodule

// File: rtl/irq_vec_ctrl.sv
`timescale 1ns/1ps
module irq_vec_ctrl
  import irq_vec_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] evt_i,
  input  logic               reg_we_i,
  input  logic               reg_bit_i,
  input  logic [ADDR_W-1:0]  reg_addr_i,
  input  logic [SEL_W-1:0]   reg_bsel_i,
  input  logic [NIB_W-1:0]   reg_wdata_i,
  output logic [NIB_W-1:0]   reg_rdata_o,
  input  logic               mie_i,
  input  logic               ack_i,
  input  logic [IDX_W-1:0]   ack_idx_i,
  output logic               vec_valid_o,
  output logic [IDX_W-1:0]   vec_idx_o,
  output logic               wake_o
);
  localparam int NIB_SEL_W = ADDR_W - 1;

  logic [NUM_SRC-1:0] req_q, en_q, qual, ack_clr;
  logic [NUM_SRC-1:0] wr_req, wr_en, wr_val;
  logic               any_pend;
  logic               bank_en;
  logic [NIB_SEL_W-1:0] nib_sel;

  assign bank_en = reg_addr_i[ADDR_W-1];
  assign nib_sel = reg_addr_i[NIB_SEL_W-1:0];

  always_comb begin
    for (int g = 0; g < NUM_SRC; g++) begin
      logic hit;
      hit = reg_we_i && (nib_sel == NIB_SEL_W'(g / NIB_W)) &&
            (!reg_bit_i || (reg_bsel_i == SEL_W'(g % NIB_W)));
      wr_val[g] = reg_bit_i ? reg_wdata_i[0] : reg_wdata_i[g % NIB_W];
      wr_req[g] = hit && !bank_en;
      wr_en[g]  = hit && bank_en;
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    for (int b = 0; b < NIB_W; b++) begin
      int g;
      g = int'(nib_sel) * NIB_W + b;
      if (g < NUM_SRC) reg_rdata_o[b] = bank_en ? en_q[g] : req_q[g];
    end
  end

  irq_flag_bank #(.N(NUM_SRC)) u_req_bank (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .set_i    (evt_i),
    .clr_i    (ack_clr),
    .wr_en_i  (wr_req),
    .wr_val_i (wr_val),
    .q_o      (req_q)
  );

  irq_flag_bank #(.N(NUM_SRC)) u_en_bank (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .set_i    ('0),
    .clr_i    ('0),
    .wr_en_i  (wr_en),
    .wr_val_i (wr_val),
    .q_o      (en_q)
  );

  assign qual = req_q & en_q;

  irq_ack_clear u_ack (
    .ack_i     (ack_i),
    .ack_idx_i (ack_idx_i),
    .qual_i    (qual),
    .clr_o     (ack_clr)
  );

  irq_vec_select u_sel (
    .qual_i (qual),
    .any_o  (any_pend),
    .idx_o  (vec_idx_o)
  );

  assign vec_valid_o = mie_i && any_pend;
  assign wake_o      = |qual;
endmodule

// File: rtl/irq_vec_ctrl_chk.sv
`timescale 1ns/1ps
module irq_vec_ctrl_chk
  import irq_vec_pkg::*;
(
  input logic               clk_i,
  input logic               rst_ni,
  input logic [NUM_SRC-1:0] evt_i,
  input logic               reg_we_i,
  input logic               mie_i,
  input logic               ack_i,
  input logic [IDX_W-1:0]   ack_idx_i,
  input logic               vec_valid_o,
  input logic               wake_o,
  input logic [NUM_SRC-1:0] req_q,
  input logic [NUM_SRC-1:0] en_q
);
  a_r4_valid_needs_mie: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vec_valid_o |-> mie_i);

  a_r3_valid_implies_wake: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vec_valid_o |-> wake_o);

  a_r2_event_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|evt_i) |=> ((req_q & $past(evt_i)) == $past(evt_i)));

  a_r9_en_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !reg_we_i |=> $stable(en_q));

  a_r8_shared_both_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && ack_idx_i == IDX_W'(SHARED_VEC) && !reg_we_i &&
     req_q[SHARED_LO] && en_q[SHARED_LO] && req_q[SHARED_HI] && en_q[SHARED_HI])
    |=> (req_q[SHARED_LO] && req_q[SHARED_HI]));

  for (genvar v = 0; v < NUM_VEC; v++) begin : g_ack
    if (v != SHARED_VEC) begin : g_single
      a_r7_ack_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ack_i && ack_idx_i == IDX_W'(v) && !reg_we_i && !evt_i[vec_src(v)])
        |=> !req_q[vec_src(v)]);
    end
  end
endmodule

bind irq_vec_ctrl irq_vec_ctrl_chk u_chk (.*);

// File: tb/irq_vec_ctrl_test.sv
`timescale 1ns/1ps
module irq_vec_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int N_RAND     = 4000;

  logic       clk_i = 0, rst_ni = 0;
  logic [9:0] evt_i = '0;
  logic       reg_we_i = 0, reg_bit_i = 0;
  logic [2:0] reg_addr_i = '0;
  logic [1:0] reg_bsel_i = '0;
  logic [3:0] reg_wdata_i = '0, reg_rdata_o;
  logic       mie_i = 0, ack_i = 0;
  logic [3:0] ack_idx_i = '0, vec_idx_o;
  logic       vec_valid_o, wake_o;

  int total = 0, bad = 0;
  bit done = 0;
  logic [9:0] m_req = '0, m_en = '0;

  irq_vec_ctrl uut (.*);

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  task automatic chk(input logic [3:0] act, input logic [3:0] exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [8:0] m_pend();
    logic [9:0] q = m_req & m_en;
    return {q[9:5], q[3] | q[4], q[2:0]};
  endfunction

  function automatic logic [3:0] m_rd(input logic [2:0] a);
    logic [3:0] r = '0;
    for (int b = 0; b < 4; b++) begin
      int g = int'(a[1:0]) * 4 + b;
      if (g < 10) r[b] = a[2] ? m_en[g] : m_req[g];
    end
    return r;
  endfunction

  task automatic cyc(input logic [9:0] ev, input logic we, input logic bm,
                     input logic [2:0] a, input logic [1:0] bs, input logic [3:0] wd,
                     input logic mie, input logic ak, input logic [3:0] ai);
    logic [8:0] p;
    logic [3:0] ei;
    logic [9:0] nreq, nen;
    @(negedge clk_i);
    evt_i = ev; reg_we_i = we; reg_bit_i = bm; reg_addr_i = a; reg_bsel_i = bs;
    reg_wdata_i = wd; mie_i = mie; ack_i = ak; ack_idx_i = ai;
    #1;
    p = m_pend();
    ei = '0;
    for (int v = 8; v >= 0; v--) if (p[v]) ei = 4'(v);
    chk({3'b0, vec_valid_o}, {3'b0, mie && (|p)}, "R4 valid");
    if (mie && (|p)) chk(vec_idx_o, ei, "R4 idx");
    chk({3'b0, wake_o}, {3'b0, |(m_req & m_en)}, "R3 wake");
    chk(reg_rdata_o, m_rd(a), "R5 read");
    nreq = m_req; nen = m_en;
    if (ak && ai < 9) begin
      if (ai == 3) begin
        logic q3 = m_req[3] & m_en[3], q4 = m_req[4] & m_en[4];
        if (q3 && !q4) nreq[3] = 0;
        if (q4 && !q3) nreq[4] = 0;
      end else nreq[(ai < 3) ? ai : ai + 1] = 0;
    end
    if (we) for (int g = 0; g < 10; g++) begin
      if (a[1:0] == 2'(g / 4) && (!bm || bs == 2'(g % 4))) begin
        if (a[2]) nen[g] = bm ? wd[0] : wd[g % 4];
        else      nreq[g] = bm ? wd[0] : wd[g % 4];
      end
    end
    nreq = nreq | ev;
    @(posedge clk_i);
    m_req = nreq; m_en = nen;
  endtask

  task automatic idle(input logic [2:0] a);
    cyc('0, 0, 0, a, 0, 0, 1, 0, 0);
  endtask

  task automatic rd(input logic [2:0] a, input logic [3:0] exp, input string tag);
    idle(a);
    #1 chk(reg_rdata_o, exp, tag);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    #(CLK_PERIOD * 2 + 1);
    chk({2'b0, vec_valid_o, wake_o}, 4'h0, "R1 outputs in reset");
    rst_ni = 1;
    rd(3'd0, 4'h0, "R1 req reset");
    rd(3'd4, 4'h0, "R1 en reset");
    cyc('0, 1, 0, 3'd4, 0, 4'hF, 0, 0, 0);
    cyc('0, 1, 0, 3'd5, 0, 4'hF, 0, 0, 0);
    cyc('0, 1, 0, 3'd6, 0, 4'hF, 0, 0, 0);
    rd(3'd6, 4'h3, "R5 upper bits ignored");
    // software set of source 3 with master enable off
    cyc('0, 1, 1, 3'd0, 2'd3, 4'h1, 0, 0, 0);
    #1 chk({3'b0, wake_o}, 4'h1, "R3 wake without mie");
    chk({3'b0, vec_valid_o}, 4'h0, "R4 gated by mie");
    idle(3'd0);
    #1 chk({vec_valid_o, vec_idx_o[2:0]}, 4'hB, "R6 software set vectors");
    cyc('0, 1, 1, 3'd1, 2'd0, 4'h1, 1, 0, 0);
    cyc('0, 0, 0, 3'd0, 0, 0, 1, 1, 4'd3);
    rd(3'd0, 4'h8, "R8 both kept lo");
    rd(3'd1, 4'h1, "R8 both kept hi");
    cyc('0, 1, 1, 3'd1, 2'd0, 4'h0, 1, 0, 0);
    cyc('0, 0, 0, 3'd0, 0, 0, 1, 1, 4'd3);
    rd(3'd0, 4'h0, "R8 single cleared");
    cyc('0, 1, 1, 3'd5, 2'd0, 4'h0, 1, 0, 0);
    cyc(10'h018, 0, 0, 3'd0, 0, 0, 1, 0, 0);
    cyc('0, 0, 0, 3'd0, 0, 0, 1, 1, 4'd3);
    rd(3'd0, 4'h0, "R8 qualified one cleared");
    rd(3'd1, 4'h1, "R8 unpermitted kept");
    rd(3'd5, 4'hE, "R9 en untouched");
    cyc(10'h020, 1, 1, 3'd1, 2'd1, 4'h0, 1, 0, 0);
    rd(3'd1, 4'h3, "R2 event beats write");
    chk(vec_idx_o, 4'd4, "R4 lowest vector");
    cyc('0, 0, 0, 3'd1, 0, 0, 1, 1, 4'd4);
    rd(3'd1, 4'h1, "R7 ack clears");
    cyc('0, 1, 0, 3'd2, 0, 4'hF, 1, 0, 0);
    rd(3'd2, 4'h3, "R5 nibble write");
    chk(vec_idx_o, 4'd7, "R4 key scan vector");
    cyc('0, 0, 0, 3'd2, 0, 0, 1, 1, 4'd7);
    rd(3'd2, 4'h2, "R7 ack vector 7");
    cyc(10'h200, 0, 0, 3'd2, 0, 0, 1, 1, 4'd8);
    rd(3'd2, 4'h2, "R2 event beats ack");
    cyc('0, 0, 0, 3'd2, 0, 0, 1, 1, 4'd12);
    rd(3'd2, 4'h2, "R7 out of range ack");

    for (int i = 0; i < N_RAND; i++) begin
      logic [9:0] ev = 10'($urandom & $urandom & $urandom);
      logic we = ($urandom % 4) == 0;
      logic ak = ($urandom % 3) == 0;
      logic [3:0] ai = (($urandom % 4) == 0) ? 4'($urandom % 10) : vec_idx_o;
      cyc(ev, we, 1'($urandom), 3'($urandom), 2'($urandom), 4'($urandom),
          ($urandom % 5) != 0, ak, ai);
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule